// File: doc/BRIEF.md
# Descriptor-Chained Audio DMA Channel

This block is one peripheral-bus DMA channel for 16-bit audio. It moves sample words between system memory and its own slice of a shared device FIFO. Software places a ring of descriptors in memory. Each descriptor is three 32-bit words: a buffer address, a count word, and a next-descriptor pointer. The count word holds the byte count and a flag that requests an interrupt when that buffer is finished. The channel is started in two steps: the descriptor pointer is loaded, and then the control word is written with its active flag set. From then on the channel follows the chain, and because the last descriptor points back to the first, it keeps running until software writes the control word again with active clear.

In transmit mode, each 32-bit memory word becomes two halfwords (one stereo frame) that are pushed into the FIFO slice and popped one at a time by the device. In receive mode the flow is reversed: the device pushes halfwords and the channel writes them to memory in pairs. The channel's part of the shared FIFO is set by a begin field and an end field, both counted in 8-byte units. A high-water mark, counted in halfwords, decides when the memory side may move a word. Software tracks progress by reading the current buffer pointer, and it sees a pending end-of-buffer interrupt in bit 0 of the control word. Reading the control word clears that interrupt.

Top module: `dma_audio_chan`

## Requirements
- R1: After reset the control readback is zero, `irq_o`, `mem_req_o`, `dev_tx_valid_o` and `dev_rx_ready_o` are low, and `bptr_o` is zero.
- R2: A control write with the active flag (bit 4) set makes the channel read its descriptor as three memory words, at the loaded pointer, pointer+4 and pointer+8, in that order. A pending request holds its address until it is granted.
- R3: In transmit mode each memory word yields two halfwords to the device, in memory order. When the little-endian flag (bit 1) is clear, bits 31:16 are sent first. When it is set, bits 15:0 are sent first.
- R4: A transmit memory read is requested only while the FIFO fill is at or below the high-water mark (control bits 15:8, in halfwords).
- R5: In receive mode the channel writes device halfwords to consecutive buffer addresses in pairs, with the earlier halfword in bits 31:16. A write is requested only while the fill is at or above the high-water mark.
- R6: After the last byte of a buffer, the channel fetches the descriptor at the next pointer, and a ring wraps back to its start. The interrupt becomes pending only if bit 31 of the finished buffer's count word was set. The byte count is in bits 15:0.
- R7: The control readback reports the pending interrupt in bit 0, and the read clears it.
- R8: A control write with the active flag clear stops the channel at once. No memory request follows, and transmit data is no longer offered.
- R9: `bptr_o` holds the buffer address loaded from the descriptor, and it advances by 4 on every granted data word.
- R10: The FIFO slice holds 4×(end−begin) halfwords. End is control bits 31:24 and begin is bits 23:16, both in 8-byte units. `dev_rx_ready_o` drops when the slice is full.
- R11: The control readback returns end, begin, high-water mark, active (bit 4), real-time (bit 3), receive (bit 2) and little-endian (bit 1) exactly as written. Bits 7:5 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 32 | Control word write data |
| ctl_re_i | input | 1 | Control word read strobe (clears the pending interrupt) |
| ctl_rdata_o | output | 32 | Control word readback |
| dptr_we_i | input | 1 | Descriptor pointer load strobe (accepted while idle) |
| dptr_wdata_i | input | AW | Descriptor pointer value |
| bptr_o | output | AW | Current buffer pointer |
| irq_o | output | 1 | End-of-buffer interrupt pending |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_gnt_i | input | 1 | Grant; completes the request in this cycle |
| mem_rdata_i | input | 32 | Read data, valid together with the grant |
| dev_tx_valid_o | output | 1 | Transmit halfword available |
| dev_tx_data_o | output | 16 | Transmit halfword |
| dev_tx_ready_i | input | 1 | Device takes the transmit halfword |
| dev_rx_valid_i | input | 1 | Device offers a receive halfword |
| dev_rx_data_i | input | 16 | Receive halfword |
| dev_rx_ready_o | output | 1 | Slice can accept a receive halfword |

## Verification
Some properties are checked on every cycle:
- the fill is at or below the mark whenever a transmit read is requested, and at or above it whenever a receive write is requested;
- the fill never exceeds the slice;
- a request holds its address until it is granted;
- the first descriptor read follows a start, and requests stop after a stop;
- the interrupt rises only out of the transfer state and clears on a read.

Other behaviour needs scenarios and can only be shown by the bench:
- the sample ordering in both endian settings;
- the pairing of receive halfwords;
- the ring wrapping across descriptors;
- the per-buffer interrupt flag;
- the buffer pointer's path;
- a slice that fills up when memory is withheld.

// File: rtl/audio_dma_pkg.sv
package audio_dma_pkg;
  localparam int unsigned CTL_IRQ_BIT = 0;
  localparam int unsigned CTL_LE_BIT  = 1;
  localparam int unsigned CTL_RX_BIT  = 2;
  localparam int unsigned CTL_RT_BIT  = 3;
  localparam int unsigned CTL_ACT_BIT = 4;
  localparam int unsigned CNT_IE_BIT  = 31;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_D_BUF,
    ST_D_CNT,
    ST_D_NXT,
    ST_XFER
  } eng_state_e;

  typedef struct packed {
    logic [7:0] fend;
    logic [7:0] fbeg;
    logic [7:0] hwm;
    logic [2:0] rsvd;
    logic       act;
    logic       rt;
    logic       rx;
    logic       le;
    logic       irq;
  } ctl_word_t;
endpackage

// File: rtl/dma_slice_fifo.sv
module dma_slice_fifo #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned PW = IW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [7:0]    beg_i,
  input  logic [7:0]    end_i,
  input  logic [1:0]    push_n_i,
  input  logic [15:0]   push_d0_i,
  input  logic [15:0]   push_d1_i,
  input  logic [1:0]    pop_n_i,
  output logic [15:0]   head0_o,
  output logic [15:0]   head1_o,
  output logic [PW-1:0] fill_o,
  output logic [PW-1:0] cap_o
);
  logic [15:0]   mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q, fill_q;
  logic [31:0]   base, lim;

  // slice bounds in halfwords, clamped to the physical FIFO
  always_comb begin
    lim  = {22'd0, end_i, 2'b00};
    base = {22'd0, beg_i, 2'b00};
    if (lim > DEPTH) lim = DEPTH;
    if (base > lim) base = lim;
  end

  assign cap_o  = PW'(lim - base);
  assign fill_o = fill_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] o);
    logic [PW:0] t;
    t = {1'b0, o} + 1'b1;
    return (t >= {1'b0, cap_o}) ? '0 : t[PW-1:0];
  endfunction

  function automatic logic [IW-1:0] idx(input logic [PW-1:0] o);
    logic [31:0] t;
    t = base + 32'(o);
    return t[IW-1:0];
  endfunction

  assign head0_o = mem_q[idx(rd_q)];
  assign head1_o = mem_q[idx(nxt(rd_q))];

  always_ff @(posedge clk_i) begin
    if (!flush_i && push_n_i != 2'd0) begin
      mem_q[idx(wr_q)] <= push_d0_i;
      if (push_n_i == 2'd2) mem_q[idx(nxt(wr_q))] <= push_d1_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      wr_q   <= '0;
      fill_q <= '0;
    end else if (flush_i) begin
      rd_q   <= '0;
      wr_q   <= '0;
      fill_q <= '0;
    end else begin
      if (push_n_i == 2'd1) wr_q <= nxt(wr_q);
      else if (push_n_i == 2'd2) wr_q <= nxt(nxt(wr_q));
      if (pop_n_i == 2'd1) rd_q <= nxt(rd_q);
      else if (pop_n_i == 2'd2) rd_q <= nxt(nxt(rd_q));
      fill_q <= fill_q + PW'(push_n_i) - PW'(pop_n_i);
    end
  end
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import audio_dma_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  input  logic        re_i,
  input  logic        irq_set_i,
  output ctl_word_t   ctl_o,
  output logic [31:0] rdata_o
);
  ctl_word_t w;
  logic [7:0] fend_q, fbeg_q, hwm_q;
  logic act_q, rt_q, rx_q, le_q, irq_q;

  assign w = ctl_word_t'(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fend_q <= '0; fbeg_q <= '0; hwm_q <= '0;
      act_q  <= 1'b0; rt_q <= 1'b0; rx_q <= 1'b0; le_q <= 1'b0;
    end else if (we_i) begin
      fend_q <= w.fend; fbeg_q <= w.fbeg; hwm_q <= w.hwm;
      act_q  <= w.act; rt_q <= w.rt; rx_q <= w.rx; le_q <= w.le;
    end
  end

  // a new completion wins over a simultaneous read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (irq_set_i) irq_q <= 1'b1;
    else if (re_i)      irq_q <= 1'b0;
  end

  always_comb begin
    ctl_o      = '0;
    ctl_o.fend = fend_q;
    ctl_o.fbeg = fbeg_q;
    ctl_o.hwm  = hwm_q;
    ctl_o.act  = act_q;
    ctl_o.rt   = rt_q;
    ctl_o.rx   = rx_q;
    ctl_o.le   = le_q;
    ctl_o.irq  = irq_q;
  end

  assign rdata_o = 32'(ctl_o);
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
  import audio_dma_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PW    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_hit_i,
  input  logic          start_i,
  input  logic          dptr_we_i,
  input  logic [AW-1:0] dptr_wdata_i,
  input  logic          rx_i,
  input  logic          le_i,
  input  logic [7:0]    hwm_i,
  input  logic [PW-1:0] fill_i,
  input  logic [PW-1:0] cap_i,
  input  logic [15:0]   head0_i,
  input  logic [15:0]   head1_i,
  input  logic          mem_gnt_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  output logic [1:0]    push_n_o,
  output logic [15:0]   push_d0_o,
  output logic [15:0]   push_d1_o,
  output logic [1:0]    pop_n_o,
  output logic          done_o,
  output logic [AW-1:0] bptr_o,
  output logic [AW-1:0] dptr_o,
  output eng_state_e    state_o
);
  eng_state_e st_q;
  logic [AW-1:0]    dptr_q, bptr_q;
  logic [CNT_W-1:0] rem_q;
  logic ie_q, ok_tx, ok_rx, rem_zero, hs;

  always_comb begin
    ok_tx    = !rx_i && (32'(fill_i) <= 32'(hwm_i)) &&
               (32'(cap_i) - 32'(fill_i) >= 32'd2);
    ok_rx    = rx_i && (32'(fill_i) >= 32'(hwm_i)) && (32'(fill_i) >= 32'd2);
    rem_zero = (rem_q == '0);
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = dptr_q;
    unique case (st_q)
      ST_D_BUF: mem_req_o = 1'b1;
      ST_D_CNT: begin mem_req_o = 1'b1; mem_addr_o = dptr_q + AW'(4); end
      ST_D_NXT: begin mem_req_o = 1'b1; mem_addr_o = dptr_q + AW'(8); end
      ST_XFER: begin
        mem_req_o  = !rem_zero && (ok_tx || ok_rx);
        mem_we_o   = rx_i;
        mem_addr_o = bptr_q;
      end
      default: ;
    endcase
    hs          = mem_req_o && mem_gnt_i && !ctl_hit_i;
    push_n_o    = (st_q == ST_XFER && !rx_i && hs) ? 2'd2 : 2'd0;
    pop_n_o     = (st_q == ST_XFER && rx_i && hs) ? 2'd2 : 2'd0;
    push_d0_o   = le_i ? mem_rdata_i[15:0] : mem_rdata_i[31:16];
    push_d1_o   = le_i ? mem_rdata_i[31:16] : mem_rdata_i[15:0];
    mem_wdata_o = le_i ? {head1_i, head0_i} : {head0_i, head1_i};
    done_o      = (st_q == ST_XFER) && rem_zero && ie_q && !ctl_hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      dptr_q <= '0;
      bptr_q <= '0;
      rem_q  <= '0;
      ie_q   <= 1'b0;
    end else if (ctl_hit_i) begin
      st_q <= start_i ? ST_D_BUF : ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (dptr_we_i) dptr_q <= dptr_wdata_i;
        ST_D_BUF: if (hs) begin
          bptr_q <= mem_rdata_i[AW-1:0];
          st_q   <= ST_D_CNT;
        end
        ST_D_CNT: if (hs) begin
          rem_q <= mem_rdata_i[CNT_W-1:0];
          ie_q  <= mem_rdata_i[CNT_IE_BIT];
          st_q  <= ST_D_NXT;
        end
        ST_D_NXT: if (hs) begin
          dptr_q <= mem_rdata_i[AW-1:0];
          st_q   <= ST_XFER;
        end
        ST_XFER: begin
          if (rem_zero) st_q <= ST_D_BUF;
          else if (hs) begin
            bptr_q <= bptr_q + AW'(4);
            rem_q  <= (rem_q > CNT_W'(4)) ? rem_q - CNT_W'(4) : '0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign bptr_o  = bptr_q;
  assign dptr_o  = dptr_q;
  assign state_o = st_q;
endmodule

// File: rtl/dma_audio_chan.sv
module dma_audio_chan
  import audio_dma_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned FIFO_DW = 8,
  parameter int unsigned CNT_W   = 16,
  localparam int unsigned DEPTH  = FIFO_DW * 4,
  localparam int unsigned PW     = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic [31:0]   ctl_wdata_i,
  input  logic          ctl_re_i,
  output logic [31:0]   ctl_rdata_o,
  input  logic          dptr_we_i,
  input  logic [AW-1:0] dptr_wdata_i,
  output logic [AW-1:0] bptr_o,
  output logic          irq_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          dev_tx_valid_o,
  output logic [15:0]   dev_tx_data_o,
  input  logic          dev_tx_ready_i,
  input  logic          dev_rx_valid_i,
  input  logic [15:0]   dev_rx_data_i,
  output logic          dev_rx_ready_o
);
  ctl_word_t     ctl;
  logic          irq_set, start, tx_pop, rx_push;
  logic [PW-1:0] fill, cap;
  logic [15:0]   head0, head1, e_d0, e_d1, f_d0, f_d1;
  logic [1:0]    e_push_n, e_pop_n, f_push_n, f_pop_n;
  logic [AW-1:0] dptr_q;
  eng_state_e    state_q;

  assign start = ctl_we_i && ctl_wdata_i[CTL_ACT_BIT];

  dma_ctl_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(ctl_we_i), .wdata_i(ctl_wdata_i), .re_i(ctl_re_i),
    .irq_set_i(irq_set), .ctl_o(ctl), .rdata_o(ctl_rdata_o)
  );

  dma_desc_engine #(.AW(AW), .CNT_W(CNT_W), .PW(PW)) u_eng (
    .clk_i, .rst_ni,
    .ctl_hit_i(ctl_we_i), .start_i(start),
    .dptr_we_i, .dptr_wdata_i,
    .rx_i(ctl.rx), .le_i(ctl.le), .hwm_i(ctl.hwm),
    .fill_i(fill), .cap_i(cap), .head0_i(head0), .head1_i(head1),
    .mem_gnt_i, .mem_rdata_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .push_n_o(e_push_n), .push_d0_o(e_d0), .push_d1_o(e_d1), .pop_n_o(e_pop_n),
    .done_o(irq_set), .bptr_o, .dptr_o(dptr_q), .state_o(state_q)
  );

  assign dev_tx_valid_o = ctl.act && !ctl.rx && (fill != '0);
  assign dev_tx_data_o  = head0;
  assign dev_rx_ready_o = ctl.act && ctl.rx && (fill < cap);
  assign tx_pop  = dev_tx_valid_o && dev_tx_ready_i;
  assign rx_push = dev_rx_valid_i && dev_rx_ready_o;

  // direction picks which side fills and which side drains the slice
  always_comb begin
    if (ctl.rx) begin
      f_push_n = {1'b0, rx_push};
      f_d0     = dev_rx_data_i;
      f_d1     = dev_rx_data_i;
      f_pop_n  = e_pop_n;
    end else begin
      f_push_n = e_push_n;
      f_d0     = e_d0;
      f_d1     = e_d1;
      f_pop_n  = {1'b0, tx_pop};
    end
  end

  dma_slice_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i(ctl_we_i), .beg_i(ctl.fbeg), .end_i(ctl.fend),
    .push_n_i(f_push_n), .push_d0_i(f_d0), .push_d1_i(f_d1),
    .pop_n_i(f_pop_n), .head0_o(head0), .head1_o(head1),
    .fill_o(fill), .cap_o(cap)
  );

  assign irq_o = ctl.irq;
endmodule

// File: rtl/dma_audio_chan_chk.sv
module dma_audio_chan_chk
  import audio_dma_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned PW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ctl_we_i,
  input logic          ctl_act_i,
  input logic          ctl_re_i,
  input logic          irq_set_i,
  input logic          irq_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_gnt_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [AW-1:0] dptr_q,
  input eng_state_e    state_q,
  input logic [PW-1:0] fill,
  input logic [PW-1:0] cap,
  input logic [7:0]    hwm
);
  // R2
  start_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && ctl_act_i |=> mem_req_o && !mem_we_o && mem_addr_o == $past(dptr_q));
  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i && !ctl_we_i |=> mem_req_o && $stable(mem_addr_o));
  // R4
  tx_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && state_q == ST_XFER |-> 32'(fill) <= 32'(hwm));
  // R5
  rx_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> 32'(fill) >= 32'(hwm) && 32'(fill) >= 2);
  // R6
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(state_q) == ST_XFER);
  // R7
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_re_i && !irq_set_i |=> !irq_o);
  // R8
  stop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && !ctl_act_i |=> !mem_req_o);
  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill <= cap);
endmodule

bind dma_audio_chan dma_audio_chan_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .ctl_we_i(ctl_we_i), .ctl_act_i(ctl_wdata_i[4]), .ctl_re_i(ctl_re_i),
  .irq_set_i(irq_set), .irq_o(irq_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_gnt_i(mem_gnt_i),
  .mem_addr_o(mem_addr_o), .dptr_q(dptr_q), .state_q(state_q),
  .fill(fill), .cap(cap), .hwm(ctl.hwm)
);

// File: tb/dma_audio_chan_tb.sv
module dma_audio_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0, ctl_re = 1'b0, dptr_we = 1'b0;
  logic [31:0] ctl_wdata = '0, ctl_rdata, dptr_wdata = '0, bptr;
  logic irq, mem_req, mem_we, mem_gnt = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready;
  logic [15:0] tx_data, rx_data = '0;

  logic [31:0] mem_m [1024];
  assign mem_rdata = mem_m[mem_addr[11:2]];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_audio_chan u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .ctl_re_i(ctl_re), .ctl_rdata_o(ctl_rdata),
    .dptr_we_i(dptr_we), .dptr_wdata_i(dptr_wdata), .bptr_o(bptr), .irq_o(irq),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata),
    .dev_tx_valid_o(tx_valid), .dev_tx_data_o(tx_data), .dev_tx_ready_i(tx_ready),
    .dev_rx_valid_i(rx_valid), .dev_rx_data_i(rx_data), .dev_rx_ready_o(rx_ready)
  );

  int total = 0, failed = 0, cyc = 0;
  // bench model state, updated at negedge
  int fill_m = 0, hw_m = 0, thr_err = 0, bptr_err = 0, irq_hi = 0;
  int log_n = 0, pop_n = 0, push_n = 0, wr_n = 0;
  logic [31:0] bptr_exp = '0;
  logic [31:0] log_a [3];
  logic [15:0] popped [64];
  logic [15:0] pushed [64];
  logic [31:0] wlog_a [16];
  logic [31:0] wlog_d [16];
  logic [31:0] dbase [3];
  int nd = 0;
  bit tx_en = 0, rx_en = 0, data_gnt_en = 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctl(input int fe, input int fb, input int hw,
                                         input bit act, input bit rt, input bit rx, input bit le);
    return {8'(fe), 8'(fb), 8'(hw), 3'b0, act, rt, rx, le, 1'b0};
  endfunction

  function automatic bit is_dbase(input logic [31:0] a);
    for (int i = 0; i < nd; i++) if (dbase[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      total++; failed++;
      $display("FAIL R2 watchdog: cycles %0d expected below %0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  // random responder and reference model; handshakes decided here complete at the next posedge
  always @(negedge clk) begin
    if (rst_n) begin
      mem_gnt  = mem_req && !ctl_we && ($urandom % 4 != 0) &&
                 (data_gnt_en || mem_addr < 32'h400);
      tx_ready = !ctl_we && tx_en && ($urandom % 3 != 0);
      rx_valid = !ctl_we && rx_en && ($urandom % 2 == 1);
      rx_data  = 16'($urandom);
      if (ctl_we) fill_m = 0;
      if (bptr !== bptr_exp) bptr_err++;
      if (irq) irq_hi++;
      if (mem_req && mem_gnt) begin
        if (log_n < 3) log_a[log_n] = mem_addr;
        log_n++;
        if (mem_addr >= 32'h400) begin
          if (!mem_we) begin
            if (fill_m > hw_m) thr_err++;
            fill_m += 2;
          end else begin
            if (fill_m < hw_m) thr_err++;
            mem_m[mem_addr[11:2]] = mem_wdata;
            if (wr_n < 16) begin wlog_a[wr_n] = mem_addr; wlog_d[wr_n] = mem_wdata; end
            wr_n++;
            fill_m -= 2;
          end
          bptr_exp = mem_addr + 4;
        end else if (is_dbase(mem_addr)) begin
          bptr_exp = mem_rdata;
        end
      end
      if (tx_valid && tx_ready) begin
        if (pop_n < 64) popped[pop_n] = tx_data;
        pop_n++; fill_m--;
      end
      if (rx_valid && rx_ready) begin
        if (push_n < 64) pushed[push_n] = rx_data;
        push_n++; fill_m++;
      end
    end
  end

  task automatic ctl_write(input logic [31:0] v);
    @(posedge clk); #1 ctl_we = 1'b1; ctl_wdata = v;
    @(posedge clk); #1 ctl_we = 1'b0;
  endtask

  task automatic ctl_read(output logic [31:0] v);
    @(posedge clk); #1 ctl_re = 1'b1; #1 v = ctl_rdata;
    @(posedge clk); #1 ctl_re = 1'b0;
  endtask

  task automatic start(input logic [31:0] dp, input logic [31:0] cw);
    @(posedge clk); #1 dptr_we = 1'b1; dptr_wdata = dp;
    @(posedge clk); #1 dptr_we = 1'b0;
    log_n = 0; pop_n = 0; push_n = 0; wr_n = 0; irq_hi = 0; thr_err = 0;
    hw_m = int'(cw[15:8]);
    ctl_write(cw);
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c, input logic [31:0] n);
    mem_m[a[11:2]] = b; mem_m[a[11:2] + 1] = c; mem_m[a[11:2] + 2] = n;
  endtask

  logic [31:0] rd, exp_w;
  logic [31:0] bufa [3];
  int blen [3];
  logic [15:0] exp_hw [64];
  int ne, mism;

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) mem_m[i] = 32'($urandom);
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(ctl_rdata == 0, "R1", "ctl readback", ctl_rdata, 0);
    chk(irq == 0 && mem_req == 0, "R1", "irq/req", {irq, mem_req}, 0);
    chk(tx_valid == 0 && rx_ready == 0, "R1", "device side", {tx_valid, rx_ready}, 0);
    chk(bptr == 0, "R1", "bptr", bptr, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R11 readback of fields, channel left inactive
    ctl_write(mk_ctl(2, 0, 4, 0, 1, 0, 0) | 32'hE1);
    ctl_read(rd);
    chk(rd == mk_ctl(2, 0, 4, 0, 1, 0, 0), "R11", "field readback", rd, mk_ctl(2, 0, 4, 0, 1, 0, 0));

    // transmit ring of three buffers, big-endian
    nd = 3;
    dbase[0] = 32'h100; dbase[1] = 32'h10C; dbase[2] = 32'h118;
    bufa[0] = 32'h400; bufa[1] = 32'h500; bufa[2] = 32'h600;
    blen[0] = 16; blen[1] = 8; blen[2] = 12;
    put_desc(dbase[0], bufa[0], 32'h8000_0000 | 16, dbase[1]);
    put_desc(dbase[1], bufa[1], 8, dbase[2]);
    put_desc(dbase[2], bufa[2], 32'h8000_0000 | 12, dbase[0]);
    ne = 0;
    for (int lap = 0; lap < 2; lap++)
      for (int d = 0; d < 3; d++)
        for (int w = 0; w < blen[d] / 4; w++) begin
          exp_w = mem_m[(bufa[d] >> 2) + w];
          exp_hw[ne] = exp_w[31:16]; exp_hw[ne + 1] = exp_w[15:0]; ne += 2;
        end
    tx_en = 1;
    start(dbase[0], mk_ctl(2, 0, 4, 1, 1, 0, 0));
    while (pop_n < ne) @(posedge clk);
    #1;
    chk(log_a[0] == 32'h100, "R2", "first fetch", log_a[0], 32'h100);
    chk(log_a[1] == 32'h104, "R2", "second fetch", log_a[1], 32'h104);
    chk(log_a[2] == 32'h108, "R2", "third fetch", log_a[2], 32'h108);
    mism = 0;
    for (int i = 0; i < ne; i++) if (popped[i] != exp_hw[i]) mism++;
    chk(mism == 0, "R3", "big-endian stream across ring wrap (R6)", mism, 0);
    chk(thr_err == 0, "R4", "reads at or below mark", thr_err, 0);
    ctl_write(mk_ctl(2, 0, 4, 0, 1, 0, 0));
    tx_en = 0;
    mism = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #2;
      if (mem_req || tx_valid) mism++;
    end
    chk(mism == 0, "R8", "quiet after stop", mism, 0);
    chk(bptr == bptr_exp, "R9", "bptr after stop", bptr, bptr_exp);
    chk(irq == 1, "R6", "pending after flagged buffer", irq, 1);
    ctl_read(rd);
    chk(rd[0] == 1'b1, "R7", "read shows pending", rd[0], 1);
    #1;
    chk(irq == 0, "R7", "cleared by read", irq, 0);
    ctl_read(rd);
    chk(rd[0] == 1'b0, "R7", "second read clear", rd[0], 0);

    // single self-looping buffer without interrupt flag, little-endian
    nd = 1; dbase[0] = 32'h300;
    put_desc(32'h300, 32'h900, 16, 32'h300);
    ne = 0;
    for (int lap = 0; lap < 2; lap++)
      for (int w = 0; w < 4; w++) begin
        exp_w = mem_m[(32'h900 >> 2) + w];
        exp_hw[ne] = exp_w[15:0]; exp_hw[ne + 1] = exp_w[31:16]; ne += 2;
      end
    tx_en = 1;
    start(32'h300, mk_ctl(2, 0, 4, 1, 0, 0, 1));
    while (pop_n < ne) @(posedge clk);
    #1;
    mism = 0;
    for (int i = 0; i < ne; i++) if (popped[i] != exp_hw[i]) mism++;
    chk(mism == 0, "R3", "little-endian stream", mism, 0);
    ctl_write(mk_ctl(2, 0, 4, 0, 0, 0, 1));
    tx_en = 0;
    chk(irq_hi == 0, "R6", "no irq when flag clear", irq_hi, 0);

    // receive ring of two buffers in the record slice
    nd = 2; dbase[0] = 32'h200; dbase[1] = 32'h20C;
    put_desc(32'h200, 32'h700, 32'h8000_0000 | 16, 32'h20C);
    put_desc(32'h20C, 32'h800, 8, 32'h200);
    rx_en = 1;
    start(32'h200, mk_ctl(4, 2, 4, 1, 0, 1, 0));
    while (wr_n < 8) @(posedge clk);
    ctl_write(mk_ctl(4, 2, 4, 0, 0, 1, 0));
    rx_en = 0;
    mism = 0;
    for (int k = 0; k < 8; k++) begin
      exp_w = (k % 6 < 4) ? 32'h700 + 32'(4 * (k % 6)) : 32'h800 + 32'(4 * (k % 6 - 4));
      if (wlog_a[k] != exp_w || wlog_d[k] != {pushed[2 * k], pushed[2 * k + 1]}) mism++;
    end
    chk(mism == 0, "R5", "paired writes and wrap", mism, 0);
    chk(thr_err == 0, "R5", "writes at or above mark", thr_err, 0);
    chk(bptr_err == 0, "R9", "bptr path", bptr_err, 0);

    // slice fill with memory withheld
    data_gnt_en = 0; rx_en = 1;
    start(32'h200, mk_ctl(4, 2, 4, 1, 0, 1, 0));
    repeat (80) @(posedge clk);
    #2;
    chk(push_n == 8, "R10", "accepted halfwords", push_n, 8);
    chk(rx_ready == 0, "R10", "ready low when full", rx_ready, 0);
    ctl_write(mk_ctl(4, 2, 4, 0, 0, 1, 0));
    rx_en = 0; data_gnt_en = 1;

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule